// File: doc/BRIEF.md
# Debug Segment Access Router

This block stands between the load/store and instruction-fetch port of a processor and three targets. The first is a small bank of debug registers. The second is a memory window served by an external debug probe. The third is the normal kernel address space. It takes one request at a time over a valid/ready handshake. It sorts the request by address window, by kind (fetch or load/store) and by byte enables, and then does one of three things: serves it locally, forwards it to the matching external port, or answers it with an error.

Two mode inputs decide whether the register window is live. The first, `regbank_off`, gives up the whole register window. The second, `ls_to_kernel`, sends only loads and stores in that window to kernel space. A probe-window transaction has no time limit. It stays open until the probe acknowledges it, and only a reset or a soft reset ends it sooner. While such a transaction is open, the watchdog enable passed through the block is forced low. Outside debug mode (`dbg_mode` low), both debug windows fall through to kernel space.

Top module: `dseg_router`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `probe_valid` and `kern_valid` are 0.
- R2: In debug mode, a request whose address lies in the probe window is forwarded to the probe port for any byte-enable pattern. The port holds `probe_valid` and keeps address, byte enables and write data stable until `probe_ack`, with no time limit.
- R3: With `regbank_off` = 1, every request in the register window goes to the kernel port, including fetches and partial-width requests, and gets no error.
- R4: With `regbank_off` = 0 and `ls_to_kernel` = 1, a load or store in the register window goes to the kernel port.
- R5: With both mode bits 0, a full-word (`req_be` = 4'b1111) load or store in the register window is served by the bank. The word index is (address − window base) / 4. Writes to indices 1 to NUM_REGS−1 read back unchanged.
- R6: With `regbank_off` = 0, a fetch from the register window gets `rsp_err` = 1, `rsp_size_err` = 0 and `rsp_rdata` = 0, and starts no external transaction.
- R7: Index 0 of the bank always reads the CAP_WORD parameter value, and writes to it have no effect.
- R8: Indices at or above NUM_REGS read as zero. Writes to them change no implemented register.
- R9: A bank load or store whose byte enables are not all ones gets `rsp_err` = 1 and `rsp_size_err` = 1, and no register is written.
- R10: Only one transaction is in flight. `req_ready` is low from the cycle after acceptance through the response cycle.
- R11: `wdt_en_out` equals `wdt_en_in`, except that it is 0 while a probe transaction is pending.
- R12: A soft reset abandons any open transaction. The next cycle shows `req_ready` = 1, no response and no external valid.
- R13: With `dbg_mode` = 0, addresses in both debug windows go to the kernel port.
- R14: A local (bank or error) response comes one cycle after acceptance. An external response comes one cycle after the acknowledge, carries that port's read data and has `rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset; abandons an open transaction |
| dbg_mode | input | 1 | Processor is in debug mode; enables both debug windows |
| regbank_off | input | 1 | Register window given up to kernel space |
| ls_to_kernel | input | 1 | Loads/stores in the register window go to kernel space |
| wdt_en_in | input | 1 | Watchdog enable from the system |
| wdt_en_out | output | 1 | Watchdog enable, held low during probe transactions |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = store, 0 = load or fetch |
| req_fetch | input | 1 | Instruction fetch |
| req_be | input | DATA_W/8 | Byte enables |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DATA_W | Read data |
| rsp_err | output | 1 | Request refused |
| rsp_size_err | output | 1 | Refused for illegal bank access size |
| probe_valid | output | 1 | Probe transaction open |
| probe_addr | output | ADDR_W | Probe address |
| probe_write | output | 1 | Probe write |
| probe_fetch | output | 1 | Probe fetch |
| probe_be | output | DATA_W/8 | Probe byte enables |
| probe_wdata | output | DATA_W | Probe write data |
| probe_ack | input | 1 | Probe completes the transaction |
| probe_rdata | input | DATA_W | Probe read data, valid with ack |
| kern_valid | output | 1 | Kernel transaction open |
| kern_addr | output | ADDR_W | Kernel address |
| kern_write | output | 1 | Kernel write |
| kern_fetch | output | 1 | Kernel fetch |
| kern_be | output | DATA_W/8 | Kernel byte enables |
| kern_wdata | output | DATA_W | Kernel write data |
| kern_ack | input | 1 | Kernel completes the transaction |
| kern_rdata | input | DATA_W | Kernel read data, valid with ack |

## Verification
The assertions assume that a target raises its acknowledge only while its own valid is high, and for a single cycle. They also assume that `soft_rst` is never raised in the same cycle as a new request. The bench responders watch their valid and pulse ack once after a set delay. The stimulus raises soft reset only while an external transaction is pending, never on an accepting edge. Mode bits change only while the block is idle, so each request is routed under stable settings.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [2:0] {
    RT_KERNEL    = 3'd0,
    RT_PROBE     = 3'd1,
    RT_REGS      = 3'd2,
    RT_BAD_FETCH = 3'd3,
    RT_BAD_SIZE  = 3'd4
  } dsr_route_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } dsr_state_e;

  // address lies in [base, base+span)
  function automatic logic in_window(input logic [63:0] addr,
                                     input logic [63:0] base,
                                     input logic [63:0] span);
    return (addr >= base) && ((addr - base) < span);
  endfunction

  // the low n byte lanes are all enabled
  function automatic logic all_lanes(input logic [7:0] be, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < n && !be[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic is_local(input dsr_route_e r);
    return (r == RT_REGS) || (r == RT_BAD_FETCH) || (r == RT_BAD_SIZE);
  endfunction

endpackage

// File: rtl/dsr_classify.sv
module dsr_classify
  import dsr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = '0,
  parameter logic [ADDR_W-1:0] REG_SPAN = '0,
  parameter logic [ADDR_W-1:0] PRB_BASE = '0,
  parameter logic [ADDR_W-1:0] PRB_SPAN = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetch,
  input  logic [BE_W-1:0]   be,
  input  logic              dbg_mode,
  input  logic              regbank_off,
  input  logic              ls_to_kernel,
  output dsr_route_e        route,
  output logic              hit_regs,
  output logic              hit_probe
);

  always_comb begin
    hit_regs  = dbg_mode && in_window(64'(addr), 64'(REG_BASE), 64'(REG_SPAN));
    hit_probe = dbg_mode && in_window(64'(addr), 64'(PRB_BASE), 64'(PRB_SPAN));
    route = RT_KERNEL;
    if (hit_probe) begin
      route = RT_PROBE;
    end else if (hit_regs && !regbank_off) begin
      if (fetch)                         route = RT_BAD_FETCH;
      else if (ls_to_kernel)             route = RT_KERNEL;
      else if (!all_lanes(8'(be), BE_W)) route = RT_BAD_SIZE;
      else                               route = RT_REGS;
    end
  end

endmodule

// File: rtl/dsr_regbank.sv
module dsr_regbank #(
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 4,
  parameter int IDX_W = 18,
  parameter logic [DATA_W-1:0] CAP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              implemented
);

  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] word_q;

  // index 0: read-only capability word
  assign word_q[0] = CAP_WORD;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && idx == IDX_W'(g))     q <= wdata;
    end
    assign word_q[g] = q;
  end

  assign implemented = (idx < IDX_W'(NUM_REGS));
  assign rdata = implemented ? word_q[idx[SEL_W-1:0]] : '0;

endmodule

// File: rtl/dsr_hold.sv
module dsr_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic              fetch,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] q_addr,
  output logic              q_write,
  output logic              q_fetch,
  output logic [BE_W-1:0]   q_be,
  output logic [DATA_W-1:0] q_wdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr  <= '0;
      q_write <= 1'b0;
      q_fetch <= 1'b0;
      q_be    <= '0;
      q_wdata <= '0;
    end else if (load) begin
      q_addr  <= addr;
      q_write <= write;
      q_fetch <= fetch;
      q_be    <= be;
      q_wdata <= wdata;
    end
  end

endmodule

// File: rtl/dseg_router.sv
module dseg_router
  import dsr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_REGS = 4,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'hFF30_0000,
  parameter logic [ADDR_W-1:0] REG_SPAN = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] PRB_BASE = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] PRB_SPAN = 32'h0010_0000,
  parameter logic [DATA_W-1:0] CAP_WORD = 32'h4D01_0003
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic                dbg_mode,
  input  logic                regbank_off,
  input  logic                ls_to_kernel,
  input  logic                wdt_en_in,
  output logic                wdt_en_out,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic                req_fetch,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                rsp_size_err,
  output logic                probe_valid,
  output logic [ADDR_W-1:0]   probe_addr,
  output logic                probe_write,
  output logic                probe_fetch,
  output logic [DATA_W/8-1:0] probe_be,
  output logic [DATA_W-1:0]   probe_wdata,
  input  logic                probe_ack,
  input  logic [DATA_W-1:0]   probe_rdata,
  output logic                kern_valid,
  output logic [ADDR_W-1:0]   kern_addr,
  output logic                kern_write,
  output logic                kern_fetch,
  output logic [DATA_W/8-1:0] kern_be,
  output logic [DATA_W-1:0]   kern_wdata,
  input  logic                kern_ack,
  input  logic [DATA_W-1:0]   kern_rdata
);

  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(REG_SPAN) - 2;

  dsr_state_e state_q;
  dsr_route_e route_q;
  dsr_route_e route_now;
  logic       hit_regs, hit_probe;

  logic [DATA_W-1:0] rdata_q;
  logic              err_q, serr_q;

  // named events for the checker
  logic accept, ev_local, ev_ext, ext_done, probe_pending, bank_wr;
  logic [IDX_W-1:0]  reg_idx;
  logic [DATA_W-1:0] bank_rdata;
  logic              bank_impl;

  logic [ADDR_W-1:0] h_addr;
  logic              h_write, h_fetch;
  logic [BE_W-1:0]   h_be;
  logic [DATA_W-1:0] h_wdata;

  dsr_classify #(
    .ADDR_W(ADDR_W), .BE_W(BE_W),
    .REG_BASE(REG_BASE), .REG_SPAN(REG_SPAN),
    .PRB_BASE(PRB_BASE), .PRB_SPAN(PRB_SPAN)
  ) u_cls (
    .addr(req_addr), .fetch(req_fetch), .be(req_be),
    .dbg_mode(dbg_mode), .regbank_off(regbank_off), .ls_to_kernel(ls_to_kernel),
    .route(route_now), .hit_regs(hit_regs), .hit_probe(hit_probe)
  );

  assign reg_idx  = IDX_W'((req_addr - REG_BASE) >> 2);
  assign accept   = (state_q == ST_IDLE) && req_valid && !soft_rst;
  assign ev_local = accept && is_local(route_now);
  assign ev_ext   = accept && !is_local(route_now);
  assign bank_wr  = accept && (route_now == RT_REGS) && req_write;
  assign ext_done = (state_q == ST_WAIT) &&
                    ((route_q == RT_PROBE) ? probe_ack : kern_ack);
  assign probe_pending = (state_q == ST_WAIT) && (route_q == RT_PROBE);

  dsr_regbank #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CAP_WORD(CAP_WORD)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(bank_wr), .idx(reg_idx),
    .wdata(req_wdata), .rdata(bank_rdata), .implemented(bank_impl)
  );

  dsr_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(ev_ext),
    .addr(req_addr), .write(req_write), .fetch(req_fetch),
    .be(req_be), .wdata(req_wdata),
    .q_addr(h_addr), .q_write(h_write), .q_fetch(h_fetch),
    .q_be(h_be), .q_wdata(h_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      route_q <= RT_KERNEL;
      rdata_q <= '0;
      err_q   <= 1'b0;
      serr_q  <= 1'b0;
    end else if (soft_rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            route_q <= route_now;
            if (is_local(route_now)) begin
              state_q <= ST_RESP;
              rdata_q <= (route_now == RT_REGS && !req_write && bank_impl) ?
                         bank_rdata : '0;
              err_q   <= (route_now != RT_REGS);
              serr_q  <= (route_now == RT_BAD_SIZE);
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (ext_done) begin
            state_q <= ST_RESP;
            rdata_q <= (route_q == RT_PROBE) ? probe_rdata : kern_rdata;
            err_q   <= 1'b0;
            serr_q  <= 1'b0;
          end
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_rdata    = rdata_q;
  assign rsp_err      = err_q;
  assign rsp_size_err = serr_q;

  assign probe_valid = probe_pending;
  assign probe_addr  = h_addr;
  assign probe_write = h_write;
  assign probe_fetch = h_fetch;
  assign probe_be    = h_be;
  assign probe_wdata = h_wdata;

  assign kern_valid  = (state_q == ST_WAIT) && (route_q == RT_KERNEL);
  assign kern_addr   = h_addr;
  assign kern_write  = h_write;
  assign kern_fetch  = h_fetch;
  assign kern_be     = h_be;
  assign kern_wdata  = h_wdata;

  assign wdt_en_out = wdt_en_in && !probe_pending;

endmodule

// File: rtl/dseg_router_chk.sv
module dseg_router_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst,
  input logic                req_ready,
  input logic                rsp_valid,
  input logic                rsp_err,
  input logic                rsp_size_err,
  input logic                probe_valid,
  input logic                probe_ack,
  input logic [ADDR_W-1:0]   probe_addr,
  input logic [DATA_W/8-1:0] probe_be,
  input logic [DATA_W-1:0]   probe_wdata,
  input logic                kern_valid,
  input logic                wdt_en_out,
  input logic                ev_local
);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);                                          // R10
  AST_READY_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);                                           // R10
  AST_PROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_ack && !soft_rst) |=>
      (probe_valid && $stable(probe_addr) && $stable(probe_be) && $stable(probe_wdata))); // R2
  AST_WDT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> !wdt_en_out);                                       // R11
  AST_SIZE_IS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_size_err) |-> rsp_err);                           // R9
  AST_ACK_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_ack && !soft_rst) |=> (rsp_valid && !rsp_err)); // R14
  AST_LOCAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local |=> rsp_valid);                                            // R14
  AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (req_ready && !rsp_valid && !probe_valid && !kern_valid)); // R12

endmodule

bind dseg_router dseg_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_size_err(rsp_size_err),
  .probe_valid(probe_valid), .probe_ack(probe_ack), .probe_addr(probe_addr),
  .probe_be(probe_be), .probe_wdata(probe_wdata), .kern_valid(kern_valid),
  .wdt_en_out(wdt_en_out), .ev_local(ev_local)
);

// File: tb/sim_dseg_router.sv
`timescale 1ns/1ps
module sim_dseg_router;

  localparam logic [31:0] RB   = 32'hFF30_0000;
  localparam logic [31:0] PB   = 32'hFF20_0000;
  localparam logic [31:0] SPAN = 32'h0010_0000;
  localparam logic [31:0] CAP  = 32'h4D01_0003;
  localparam logic [31:0] KADR = 32'h8000_1000;
  localparam logic [31:0] PMSK = 32'h5A5A_0000;
  localparam logic [31:0] KMSK = 32'h0F0F_0000;

  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic dbg_mode = 1, regbank_off = 0, ls_to_kernel = 0, wdt_en_in = 1;
  logic wdt_en_out, req_ready, rsp_valid, rsp_err, rsp_size_err;
  logic req_valid = 0, req_write = 0, req_fetch = 0;
  logic [31:0] req_addr = 0, req_wdata = 0, rsp_rdata;
  logic [3:0] req_be = 0;
  logic probe_valid, probe_write, probe_fetch, kern_valid, kern_write, kern_fetch;
  logic [31:0] probe_addr, probe_wdata, kern_addr, kern_wdata;
  logic [3:0] probe_be, kern_be;
  logic probe_ack = 0, kern_ack = 0;
  logic [31:0] probe_rdata = 0, kern_rdata = 0;

  always #4 clk = ~clk;

  dseg_router u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // requirement-level routing: 0 kernel, 1 probe, 2 bank, 3 fetch refused, 4 size refused
  function automatic int route_of(input logic [31:0] a, input bit f, input logic [3:0] be,
                                  input bit dbg, input bit off, input bit lsk);
    bit in_p, in_r;
    in_p = dbg && (a >= PB) && (a - PB < SPAN);
    in_r = dbg && (a >= RB) && (a - RB < SPAN);
    if (in_p) return 1;
    if (!in_r || off) return 0;
    if (f) return 3;
    if (lsk) return 0;
    if (be != 4'b1111) return 4;
    return 2;
  endfunction

  // behavioural reference model
  int m_st, m_rt;
  logic [31:0] m_rd, m_addr, m_wd;
  logic [3:0]  m_be;
  bit m_err, m_serr, m_wr, m_fe;
  logic [31:0] mreg [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_rt = 0; m_rd = 0; m_err = 0; m_serr = 0;
      foreach (mreg[i]) mreg[i] = 0;
    end else if (soft_rst) begin
      m_st = 0;
    end else if (m_st == 0) begin
      if (req_valid) begin
        m_rt = route_of(req_addr, req_fetch, req_be, dbg_mode, regbank_off, ls_to_kernel);
        if (m_rt >= 2) begin
          int idx;
          idx = int'((req_addr - RB) >> 2);
          m_rd = 0; m_err = (m_rt != 2); m_serr = (m_rt == 4);
          if (m_rt == 2 && !req_write) m_rd = (idx == 0) ? CAP : (idx < 4 ? mreg[idx] : 0);
          if (m_rt == 2 && req_write && idx >= 1 && idx < 4) mreg[idx] = req_wdata;
          m_st = 1;
        end else begin
          m_addr = req_addr; m_wd = req_wdata; m_be = req_be; m_wr = req_write; m_fe = req_fetch;
          m_st = 2;
        end
      end
    end else if (m_st == 1) begin
      m_st = 0;
    end else begin
      if (m_rt == 1 && probe_ack) begin m_rd = probe_rdata; m_err = 0; m_serr = 0; m_st = 1; end
      if (m_rt == 0 && kern_ack)  begin m_rd = kern_rdata;  m_err = 0; m_serr = 0; m_st = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == (m_st == 0), "R10 req_ready", 32'(req_ready), 32'(m_st == 0));
      chk(rsp_valid == (m_st == 1), "R14 rsp_valid", 32'(rsp_valid), 32'(m_st == 1));
      chk(probe_valid == (m_st == 2 && m_rt == 1), "R2 probe_valid", 32'(probe_valid), 32'(m_st == 2 && m_rt == 1));
      chk(kern_valid == (m_st == 2 && m_rt == 0), "R3 kern_valid", 32'(kern_valid), 32'(m_st == 2 && m_rt == 0));
      chk(wdt_en_out == (wdt_en_in && !(m_st == 2 && m_rt == 1)), "R11 wdt_en_out",
          32'(wdt_en_out), 32'(wdt_en_in && !(m_st == 2 && m_rt == 1)));
      if (m_st == 1) begin
        chk(rsp_rdata == m_rd, "R14 rsp_rdata", rsp_rdata, m_rd);
        chk(rsp_err == m_err, "R6 rsp_err", 32'(rsp_err), 32'(m_err));
        chk(rsp_size_err == m_serr, "R9 rsp_size_err", 32'(rsp_size_err), 32'(m_serr));
      end
      if (m_st == 2 && m_rt == 1)
        chk(probe_addr == m_addr && probe_be == m_be && probe_wdata == m_wd &&
            probe_write == m_wr && probe_fetch == m_fe, "R2 probe fields", probe_addr, m_addr);
      if (m_st == 2 && m_rt == 0)
        chk(kern_addr == m_addr && kern_be == m_be && kern_wdata == m_wd &&
            kern_write == m_wr && kern_fetch == m_fe, "R3 kern fields", kern_addr, m_addr);
    end
  end

  // target responders
  int prb_delay = 0, pcnt = 0, kcnt = 0;
  bit saw_prb = 0, saw_kern = 0;
  always @(negedge clk) begin
    if (probe_valid) saw_prb = 1;
    if (kern_valid) saw_kern = 1;
    if (probe_valid && !probe_ack) begin
      if (pcnt >= prb_delay) begin probe_ack <= 1; probe_rdata <= probe_addr ^ PMSK; end
      else pcnt++;
    end else begin probe_ack <= 0; pcnt = 0; end
    if (kern_valid && !kern_ack) begin
      if (kcnt >= 2) begin kern_ack <= 1; kern_rdata <= kern_addr ^ KMSK; end
      else kcnt++;
    end else begin kern_ack <= 0; kcnt = 0; end
  end

  task automatic issue(input logic [31:0] a, input bit w, input bit f,
                       input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    req_addr = a; req_write = w; req_fetch = f; req_be = be; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic xact(input logic [31:0] a, input bit w, input bit f, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd, output bit e, output bit se);
    saw_prb = 0; saw_kern = 0;
    issue(a, w, f, be, wd);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata; e = rsp_err; se = rsp_size_err;
    @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; bit e, se;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !probe_valid && !kern_valid, "R1 reset state",
        {28'd0, req_ready, rsp_valid, probe_valid, kern_valid}, 32'h8);
    rst_n = 1;
    @(negedge clk);

    xact(RB, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == CAP && !e, "R7 capability read", rd, CAP);
    xact(RB + 4, 1, 0, 4'hF, 32'h1111_2222, rd, e, se);
    xact(RB + 12, 1, 0, 4'hF, 32'hCAFE_0003, rd, e, se);
    xact(RB + 4, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == 32'h1111_2222 && !saw_kern && !saw_prb, "R5 bank readback idx1", rd, 32'h1111_2222);
    xact(RB + 12, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == 32'hCAFE_0003, "R5 bank readback idx3", rd, 32'hCAFE_0003);

    xact(RB, 1, 0, 4'hF, 32'hDEAD_BEEF, rd, e, se);
    xact(RB, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == CAP, "R7 capability write ignored", rd, CAP);

    xact(RB + 32'h40, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == 0 && !e, "R8 unimplemented read zero", rd, 0);
    xact(RB + 32'h14, 1, 0, 4'hF, 32'h7777_7777, rd, e, se);
    xact(RB + 4, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == 32'h1111_2222, "R8 unimplemented write discarded", rd, 32'h1111_2222);

    xact(RB + 8, 1, 0, 4'b0011, 32'h9999_9999, rd, e, se);
    chk(e && se, "R9 partial size refused", {30'd0, e, se}, 32'h3);
    xact(RB + 8, 0, 0, 4'hF, 0, rd, e, se);
    chk(rd == 0, "R9 partial write not performed", rd, 0);

    xact(RB, 0, 1, 4'hF, 0, rd, e, se);
    chk(e && !se && rd == 0 && !saw_kern && !saw_prb, "R6 fetch refused", {30'd0, e, se}, 32'h2);

    @(negedge clk); ls_to_kernel = 1;
    xact(RB + 4, 0, 0, 4'hF, 0, rd, e, se);
    chk(saw_kern && !e && rd == ((RB + 4) ^ KMSK), "R4 load to kernel", rd, (RB + 4) ^ KMSK);
    @(negedge clk); ls_to_kernel = 0; regbank_off = 1;
    xact(RB + 8, 0, 1, 4'hF, 0, rd, e, se);
    chk(saw_kern && !e && rd == ((RB + 8) ^ KMSK), "R3 fetch to kernel", rd, (RB + 8) ^ KMSK);
    xact(RB + 9, 1, 0, 4'b0010, 32'h55, rd, e, se);
    chk(saw_kern && !e && !se, "R3 partial store to kernel", {31'd0, e}, 0);
    @(negedge clk); regbank_off = 0;

    xact(PB + 3, 1, 0, 4'b1000, 32'hAB00_0000, rd, e, se);
    chk(saw_prb && !e, "R2 probe byte store", {31'd0, e}, 0);
    prb_delay = 60;
    xact(PB + 32'h100, 0, 1, 4'hF, 0, rd, e, se);
    chk(saw_prb && rd == ((PB + 32'h100) ^ PMSK), "R2 probe slow fetch", rd, (PB + 32'h100) ^ PMSK);

    xact(KADR, 0, 0, 4'hF, 0, rd, e, se);
    chk(saw_kern && rd == (KADR ^ KMSK), "R14 kernel data", rd, KADR ^ KMSK);

    @(negedge clk); dbg_mode = 0;
    xact(RB, 0, 0, 4'hF, 0, rd, e, se);
    chk(saw_kern && !saw_prb && rd == (RB ^ KMSK), "R13 reg window outside debug", rd, RB ^ KMSK);
    xact(PB, 0, 0, 4'hF, 0, rd, e, se);
    chk(saw_kern && !saw_prb && rd == (PB ^ KMSK), "R13 probe window outside debug", rd, PB ^ KMSK);
    @(negedge clk); dbg_mode = 1;

    prb_delay = 100000;
    issue(PB + 8, 0, 0, 4'hF, 0);
    repeat (20) @(negedge clk);
    chk(probe_valid && !wdt_en_out && !req_ready, "R11 wdt low while probe pending",
        {29'd0, probe_valid, wdt_en_out, req_ready}, 32'h4);
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
    chk(req_ready && !rsp_valid && !probe_valid, "R12 soft reset abandons",
        {29'd0, req_ready, rsp_valid, probe_valid}, 32'h4);
    chk(wdt_en_out, "R11 wdt restored", 32'(wdt_en_out), 1);
    prb_delay = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule